// File: doc/BRIEF.md
# Exception Stack Frame Sequencer

This block runs exception entry and exception return for a 32-bit processor core. On entry the core hands over a vector number, the current program counter, the status register, the stack pointer, the vector base register, a flag that marks a hardware interrupt, and the pending interrupt level. The block rounds the stack pointer down to a longword boundary and writes a two-longword frame below it: the return PC first, then a format longword. It then reads the handler address from the vector table. When the sequence ends it presents the new PC, status register and stack pointer to the core.

On return the block reads the format longword and the saved PC from the current stack pointer. It puts the original stack-pointer misalignment back from the format longword and restores the status register. It also decides, combinationally, whether a pending hardware interrupt may be taken against the current interrupt mask. A hardware entry that is not permitted is dropped. All memory traffic goes through a single 32-bit request/acknowledge port, one access per acknowledge.

Top module: `exc_frame_seq`

## Requirements
- R1: After reset, busy_o, done_o and mem_req_o are low.
- R2: An entry rounds sp_i down to a multiple of 4 (call this A) and makes exactly three accesses in this order: write the return PC at A-4, write the format longword at A-8, read the handler address at vbr_i + 4*vec_i. The read value becomes pc_o, and sp_o becomes A-8.
- R3: The format longword has bit 31 clear and bit 30 set. Bits 29:28 hold sp_i[1:0] from before rounding, bits 27:16 hold 4*vec_i, and bits 15:0 hold sr_i as it was before entry.
- R4: A software entry with vec_i in TRAP_BASE..TRAP_BASE+TRAP_CNT-1 (32..47 by default) saves pc_i+2 as the return PC. Every other software entry, and every hardware entry whatever its vector, saves pc_i unchanged.
- R5: After an entry, sr_o is sr_i with bit 13 (supervisor) set. A hardware entry also writes pend_lvl_i into bits 10:8 (interrupt mask) and clears bit 12 (master).
- R6: irq_take_o is high exactly when pend_lvl_i is strictly greater than sr_i[10:8]. A hardware entry request made while irq_take_o is low is ignored: no access is made and busy_o stays low.
- R7: A return reads the format longword F at sp_i, then the PC at sp_i+4. When it ends, pc_o is the second value read, sr_o is F[15:0], and sp_o is (sp_i OR F[29:28]) + 8.
- R8: Once an access is requested, mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o hold their values until mem_ack_i is seen high at a clock edge. Each acknowledged access is completed once.
- R9: busy_o rises in the cycle after a request is accepted. done_o is a one-cycle pulse in the cycle after the final acknowledge, and busy_o is low in that cycle. Entry or return requests made while busy_o is high are ignored. If both requests arrive together, entry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| entry_req_i | input | 1 | Start an exception entry |
| ret_req_i | input | 1 | Start an exception return |
| hw_i | input | 1 | Entry is a hardware interrupt |
| vec_i | input | VEC_W | Vector number |
| pc_i | input | 32 | Current program counter |
| sr_i | input | 16 | Current status register |
| sp_i | input | 32 | Current supervisor stack pointer |
| vbr_i | input | 32 | Vector base register |
| pend_lvl_i | input | 3 | Pending hardware interrupt level |
| irq_take_o | output | 1 | Pending interrupt may be taken |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Access byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access acknowledge |
| pc_o | output | 32 | New program counter |
| sr_o | output | 16 | New status register |
| sp_o | output | 32 | New stack pointer |

## Verification
The hardest case to reach from the ports is a second request arriving while a sequence is still waiting on the memory port. The bench's memory responder adds several wait cycles per access, so the sequence stays in flight long enough for the stimulus to pulse both entry and return requests mid-sequence. The responder logs every access, which makes it possible to show that exactly three accesses happened and none followed. A second hard case is a misaligned stack pointer that must be carried through a full entry and return. This is reached by chaining an entry from an odd address with a return that pops the frame the entry just wrote, and by checking that the original address comes back.

// File: rtl/exc_frame_pkg.sv
`timescale 1ns/1ps
package exc_frame_pkg;
  localparam int SR_W     = 16;
  localparam int LVL_W    = 3;
  localparam int SR_S_BIT = 13;
  localparam int SR_M_BIT = 12;
  localparam int SR_I_LO  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PC,
    ST_PUSH_FMT,
    ST_LOAD_VEC,
    ST_POP_FMT,
    ST_POP_PC
  } seq_st_e;
endpackage

// File: rtl/exc_frame_calc.sv
`timescale 1ns/1ps
module exc_frame_calc
  import exc_frame_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int TRAP_BASE = 32,
  parameter int TRAP_CNT  = 16
) (
  input  logic             hw_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [31:0]      pc_i,
  input  logic [SR_W-1:0]  sr_i,
  input  logic [31:0]      sp_i,
  input  logic [LVL_W-1:0] pend_lvl_i,
  output logic [31:0]      ret_pc_o,
  output logic [31:0]      fmt_o,
  output logic [SR_W-1:0]  sr_new_o,
  output logic [31:0]      sp_top_o,
  output logic [31:0]      vec_off_o
);
  localparam logic [VEC_W-1:0] TRAP_LO = VEC_W'(TRAP_BASE);
  localparam logic [VEC_W-1:0] TRAP_HI = VEC_W'(TRAP_BASE + TRAP_CNT - 1);

  logic is_trap;

  always_comb begin
    vec_off_o = {{(32-VEC_W-2){1'b0}}, vec_i, 2'b00};
    is_trap   = !hw_i && (vec_i >= TRAP_LO) && (vec_i <= TRAP_HI);
    ret_pc_o  = is_trap ? pc_i + 32'd2 : pc_i;
    fmt_o     = 32'h4000_0000 | {2'b00, sp_i[1:0], 28'h0} |
                (vec_off_o << 16) | {16'h0, sr_i};
    sp_top_o  = {sp_i[31:2], 2'b00};
    sr_new_o  = sr_i;
    sr_new_o[SR_S_BIT] = 1'b1;
    if (hw_i) begin
      sr_new_o[SR_I_LO +: LVL_W] = pend_lvl_i;
      sr_new_o[SR_M_BIT]         = 1'b0;
    end
  end
endmodule

// File: rtl/exc_irq_gate.sv
`timescale 1ns/1ps
module exc_irq_gate
  import exc_frame_pkg::*;
(
  input  logic [LVL_W-1:0] mask_i,
  input  logic [LVL_W-1:0] pend_lvl_i,
  output logic             take_o
);
  assign take_o = pend_lvl_i > mask_i;
endmodule

// File: rtl/exc_seq_ctrl.sv
`timescale 1ns/1ps
module exc_seq_ctrl
  import exc_frame_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_entry_i,
  input  logic            start_ret_i,
  input  logic [31:0]     ret_pc_i,
  input  logic [31:0]     fmt_i,
  input  logic [SR_W-1:0] sr_new_i,
  input  logic [31:0]     sp_top_i,
  input  logic [31:0]     sp_raw_i,
  input  logic [31:0]     vec_addr_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [31:0]     mem_addr_o,
  output logic [31:0]     mem_wdata_o,
  input  logic [31:0]     mem_rdata_i,
  input  logic            mem_ack_i,
  output logic [31:0]     pc_o,
  output logic [SR_W-1:0] sr_o,
  output logic [31:0]     sp_o
);
  seq_st_e         st_q;
  logic [31:0]     sp_q, pc_q, fmt_q, vaddr_q;
  logic [SR_W-1:0] srn_q;
  logic            done_q;

  always_comb begin
    mem_we_o    = 1'b0;
    mem_addr_o  = 32'h0;
    mem_wdata_o = 32'h0;
    unique case (st_q)
      ST_PUSH_PC:  begin mem_we_o = 1'b1; mem_addr_o = sp_q - 32'd4; mem_wdata_o = pc_q; end
      ST_PUSH_FMT: begin mem_we_o = 1'b1; mem_addr_o = sp_q - 32'd8; mem_wdata_o = fmt_q; end
      ST_LOAD_VEC: mem_addr_o = vaddr_q;
      ST_POP_FMT:  mem_addr_o = sp_q;
      ST_POP_PC:   mem_addr_o = sp_q + 32'd4;
      default: ;
    endcase
  end

  assign mem_req_o = (st_q != ST_IDLE);
  assign busy_o    = mem_req_o;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sp_q    <= '0;
      pc_q    <= '0;
      fmt_q   <= '0;
      vaddr_q <= '0;
      srn_q   <= '0;
      done_q  <= 1'b0;
      pc_o    <= '0;
      sr_o    <= '0;
      sp_o    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_entry_i) begin
            sp_q    <= sp_top_i;
            pc_q    <= ret_pc_i;
            fmt_q   <= fmt_i;
            srn_q   <= sr_new_i;
            vaddr_q <= vec_addr_i;
            st_q    <= ST_PUSH_PC;
          end else if (start_ret_i) begin
            sp_q <= sp_raw_i;
            st_q <= ST_POP_FMT;
          end
        end
        ST_PUSH_PC:  if (mem_ack_i) st_q <= ST_PUSH_FMT;
        ST_PUSH_FMT: if (mem_ack_i) st_q <= ST_LOAD_VEC;
        ST_LOAD_VEC: if (mem_ack_i) begin
          pc_o   <= mem_rdata_i;
          sr_o   <= srn_q;
          sp_o   <= sp_q - 32'd8;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        ST_POP_FMT: if (mem_ack_i) begin
          fmt_q <= mem_rdata_i;
          st_q  <= ST_POP_PC;
        end
        ST_POP_PC: if (mem_ack_i) begin
          pc_o   <= mem_rdata_i;
          sr_o   <= fmt_q[SR_W-1:0];
          sp_o   <= (sp_q | {30'h0, fmt_q[29:28]}) + 32'd8;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
    $stable(mem_we_o) && $stable(mem_wdata_o));

  // R2
  push_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PUSH_PC) && mem_ack_i |=>
    mem_we_o && (mem_addr_o == $past(mem_addr_o) - 32'd4));

  // R7
  pop_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_POP_FMT) && mem_ack_i |=>
    !mem_we_o && (mem_addr_o == $past(mem_addr_o) + 32'd4));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R5
  entry_super_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && $past(st_q == ST_LOAD_VEC) |-> sr_o[SR_S_BIT]);
endmodule

// File: rtl/exc_frame_seq.sv
`timescale 1ns/1ps
module exc_frame_seq
  import exc_frame_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int TRAP_BASE = 32,
  parameter int TRAP_CNT  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             entry_req_i,
  input  logic             ret_req_i,
  input  logic             hw_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [31:0]      pc_i,
  input  logic [SR_W-1:0]  sr_i,
  input  logic [31:0]      sp_i,
  input  logic [31:0]      vbr_i,
  input  logic [LVL_W-1:0] pend_lvl_i,
  output logic             irq_take_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [31:0]      mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic [31:0]      mem_rdata_i,
  input  logic             mem_ack_i,
  output logic [31:0]      pc_o,
  output logic [SR_W-1:0]  sr_o,
  output logic [31:0]      sp_o
);
  logic [31:0]     ret_pc, fmt, sp_top, vec_off;
  logic [SR_W-1:0] sr_new;
  logic            start_entry;

  exc_frame_calc #(
    .VEC_W(VEC_W), .TRAP_BASE(TRAP_BASE), .TRAP_CNT(TRAP_CNT)
  ) u_calc (
    .hw_i(hw_i), .vec_i(vec_i), .pc_i(pc_i), .sr_i(sr_i), .sp_i(sp_i),
    .pend_lvl_i(pend_lvl_i), .ret_pc_o(ret_pc), .fmt_o(fmt),
    .sr_new_o(sr_new), .sp_top_o(sp_top), .vec_off_o(vec_off)
  );

  exc_irq_gate u_gate (
    .mask_i(sr_i[SR_I_LO +: LVL_W]), .pend_lvl_i(pend_lvl_i), .take_o(irq_take_o)
  );

  assign start_entry = entry_req_i && (!hw_i || irq_take_o);

  exc_seq_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_entry_i(start_entry), .start_ret_i(ret_req_i),
    .ret_pc_i(ret_pc), .fmt_i(fmt), .sr_new_i(sr_new), .sp_top_i(sp_top),
    .sp_raw_i(sp_i), .vec_addr_i(vbr_i + vec_off),
    .busy_o(busy_o), .done_o(done_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
    .pc_o(pc_o), .sr_o(sr_o), .sp_o(sp_o)
  );

  // R6
  hw_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && entry_req_i && hw_i && !irq_take_o && !ret_req_i |=> !busy_o);
endmodule

// File: tb/tb_exc_frame_seq.sv
`timescale 1ns/1ps
module tb_exc_frame_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        entry_req = 1'b0, ret_req = 1'b0, hw = 1'b0;
  logic [7:0]  vec = '0;
  logic [31:0] pc = '0, sp = '0, vbr = '0;
  logic [15:0] sr = '0;
  logic [2:0]  pend = '0;
  logic        irq_take, busy, done, mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0, pc_out, sp_out;
  logic [15:0] sr_out;

  int checks = 0, failures = 0;
  int lat = 0;
  logic [31:0] mem [0:255];
  int          acc_n = 0;
  logic [31:0] acc_addr [0:15];
  logic        acc_we   [0:15];

  always #4 clk = ~clk;

  exc_frame_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .entry_req_i(entry_req), .ret_req_i(ret_req),
    .hw_i(hw), .vec_i(vec), .pc_i(pc), .sr_i(sr), .sp_i(sp), .vbr_i(vbr),
    .pend_lvl_i(pend), .irq_take_o(irq_take), .busy_o(busy), .done_o(done),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .pc_o(pc_out), .sr_o(sr_out), .sp_o(sp_out)
  );

  // memory responder
  initial begin
    int wcnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        wcnt = 0;
      end else if (mem_req) begin
        if (wcnt >= lat) begin
          if (acc_n < 16) begin
            acc_addr[acc_n] = mem_addr;
            acc_we[acc_n]   = mem_we;
          end
          acc_n = acc_n + 1;
          if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
          else mem_rdata = mem[mem_addr[9:2]];
          mem_ack = 1'b1;
          wcnt = 0;
        end else wcnt = wcnt + 1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures = failures + 1;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
    end
  endtask

  function automatic logic [31:0] exp_fmt(input logic [31:0] s, input logic [7:0] v, input logic [15:0] r);
    logic [31:0] f;
    f = 32'h4000_0000;
    f[29:28] = s[1:0];
    f[27:16] = {2'b00, v, 2'b00};
    f[15:0]  = r;
    return f;
  endfunction

  task automatic do_entry(input bit h, input logic [7:0] v, input logic [31:0] p,
                          input logic [15:0] r, input logic [31:0] s, input logic [2:0] lv,
                          output bit got);
    acc_n = 0;
    @(negedge clk);
    hw = h; vec = v; pc = p; sr = r; sp = s; pend = lv; entry_req = 1'b1;
    @(negedge clk);
    entry_req = 1'b0;
    wait_done(got);
  endtask

  task automatic do_return(input logic [31:0] s, output bit got);
    acc_n = 0;
    @(negedge clk);
    sp = s; ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    wait_done(got);
  endtask

  task automatic t_reset;
    chk(!busy, "R1 busy after reset", 32'(busy), 0);
    chk(!done, "R1 done after reset", 32'(done), 0);
    chk(!mem_req, "R1 mem_req after reset", 32'(mem_req), 0);
  endtask

  task automatic t_sw_entry;
    bit got;
    logic [31:0] a;
    lat = 1;
    vbr = 32'h100;
    mem[(32'h100 + 20) >> 2] = 32'h0000_0A00;
    do_entry(1'b0, 8'd5, 32'h1000, 16'h0704, 32'h3F0, 3'd0, got);
    a = 32'h3F0;
    chk(got, "R9 entry done pulse", 32'(got), 1);
    chk(!busy, "R9 busy low with done", 32'(busy), 0);
    chk(acc_n == 3, "R2 entry access count", acc_n, 3);
    chk(acc_we[0] && acc_addr[0] == a - 4, "R2 first access write PC", acc_addr[0], a - 4);
    chk(acc_we[1] && acc_addr[1] == a - 8, "R2 second access write format", acc_addr[1], a - 8);
    chk(!acc_we[2] && acc_addr[2] == 32'h114, "R2 third access vector read", acc_addr[2], 32'h114);
    chk(mem[(a - 4) >> 2] == 32'h1000, "R4 non-trap saved PC", mem[(a - 4) >> 2], 32'h1000);
    chk(mem[(a - 8) >> 2] == exp_fmt(a, 8'd5, 16'h0704), "R3 format word",
        mem[(a - 8) >> 2], exp_fmt(a, 8'd5, 16'h0704));
    chk(pc_out == 32'h0000_0A00, "R2 handler PC", pc_out, 32'h0A00);
    chk(sp_out == a - 8, "R2 new SP", sp_out, a - 8);
    chk(sr_out == 16'h2704, "R5 software SR", 32'(sr_out), 32'h2704);
    @(negedge clk);
    chk(!done, "R9 done lasts one cycle", 32'(done), 0);
  endtask

  task automatic t_trap_roundtrip;
    bit got;
    logic [31:0] f;
    lat = 0;
    vbr = 32'h100;
    mem[(32'h100 + 35*4) >> 2] = 32'h0000_0B00;
    do_entry(1'b0, 8'd35, 32'h2000, 16'h0000, 32'h3F3, 3'd0, got);
    f = exp_fmt(32'h3F3, 8'd35, 16'h0000);
    chk(got && acc_addr[0] == 32'h3EC, "R2 misaligned SP rounded down", acc_addr[0], 32'h3EC);
    chk(mem[32'h3EC >> 2] == 32'h2002, "R4 trap saves PC+2", mem[32'h3EC >> 2], 32'h2002);
    chk(mem[32'h3E8 >> 2] == f, "R3 format keeps misalignment", mem[32'h3E8 >> 2], f);
    chk(sp_out == 32'h3E8, "R2 SP after misaligned entry", sp_out, 32'h3E8);
    do_return(32'h3E8, got);
    chk(got && acc_n == 2, "R7 return access count", acc_n, 2);
    chk(!acc_we[0] && acc_addr[0] == 32'h3E8, "R7 format read first", acc_addr[0], 32'h3E8);
    chk(!acc_we[1] && acc_addr[1] == 32'h3EC, "R7 PC read second", acc_addr[1], 32'h3EC);
    chk(sp_out == 32'h3F3, "R7 SP restored with misalignment", sp_out, 32'h3F3);
    chk(pc_out == 32'h2002, "R7 PC restored", pc_out, 32'h2002);
    chk(sr_out == 16'h0000, "R7 SR restored", 32'(sr_out), 0);
  endtask

  task automatic t_trap_edges;
    bit got;
    vbr = 32'h100;
    do_entry(1'b0, 8'd31, 32'h3000, 16'h0000, 32'h3F0, 3'd0, got);
    chk(mem[32'h3EC >> 2] == 32'h3000, "R4 vector below trap range", mem[32'h3EC >> 2], 32'h3000);
    do_entry(1'b0, 8'd47, 32'h3000, 16'h0000, 32'h3F0, 3'd0, got);
    chk(mem[32'h3EC >> 2] == 32'h3002, "R4 last trap vector", mem[32'h3EC >> 2], 32'h3002);
    do_entry(1'b0, 8'd48, 32'h3000, 16'h0000, 32'h3F0, 3'd0, got);
    chk(mem[32'h3EC >> 2] == 32'h3000, "R4 vector above trap range", mem[32'h3EC >> 2], 32'h3000);
  endtask

  task automatic t_hw_entry;
    bit got;
    lat = 2;
    vbr = 32'h100;
    mem[(32'h100 + 40*4) >> 2] = 32'h0000_0C00;
    do_entry(1'b1, 8'd40, 32'h4000, 16'h1300, 32'h3F0, 3'd5, got);
    chk(got, "R6 accepted hardware entry completes", 32'(got), 1);
    chk(mem[32'h3EC >> 2] == 32'h4000, "R4 hardware entry keeps PC", mem[32'h3EC >> 2], 32'h4000);
    chk(mem[32'h3E8 >> 2] == exp_fmt(32'h3F0, 8'd40, 16'h1300), "R3 hardware format keeps old SR",
        mem[32'h3E8 >> 2], exp_fmt(32'h3F0, 8'd40, 16'h1300));
    chk(sr_out == 16'h2500, "R5 hardware SR mask and master", 32'(sr_out), 32'h2500);
    chk(pc_out == 32'h0C00, "R2 hardware handler PC", pc_out, 32'h0C00);
  endtask

  task automatic t_hw_refuse;
    @(negedge clk);
    hw = 1'b1; sr = 16'h0300; pend = 3'd3;
    #1;
    chk(!irq_take, "R6 equal level refused", 32'(irq_take), 0);
    pend = 3'd4;
    #1;
    chk(irq_take, "R6 higher level taken", 32'(irq_take), 1);
    sr = 16'h0700; pend = 3'd7;
    #1;
    chk(!irq_take, "R6 level 7 against mask 7", 32'(irq_take), 0);
    acc_n = 0;
    sr = 16'h0300; pend = 3'd3; entry_req = 1'b1;
    @(negedge clk);
    entry_req = 1'b0;
    chk(!busy, "R6 refused entry stays idle", 32'(busy), 0);
    repeat (8) @(negedge clk);
    chk(acc_n == 0, "R6 refused entry makes no access", acc_n, 0);
    hw = 1'b0;
  endtask

  task automatic t_busy_ignore;
    bit got;
    lat = 3;
    vbr = 32'h100;
    mem[(32'h100 + 9*4) >> 2] = 32'h0000_0D00;
    acc_n = 0;
    @(negedge clk);
    hw = 1'b0; vec = 8'd9; pc = 32'h5000; sr = 16'h0000; sp = 32'h3F0; entry_req = 1'b1;
    @(negedge clk);
    entry_req = 1'b0;
    chk(busy, "R9 busy after accept", 32'(busy), 1);
    repeat (2) @(negedge clk);
    ret_req = 1'b1; entry_req = 1'b1; vec = 8'd1; sp = 32'h200;
    @(negedge clk);
    ret_req = 1'b0; entry_req = 1'b0;
    wait_done(got);
    chk(got && acc_n == 3, "R9 mid-sequence requests ignored", acc_n, 3);
    chk(pc_out == 32'h0D00, "R8 waited accesses give correct handler", pc_out, 32'h0D00);
    repeat (6) @(negedge clk);
    chk(!busy && acc_n == 3, "R9 no sequence started afterwards", acc_n, 3);
    // simultaneous requests: entry wins
    lat = 0;
    acc_n = 0;
    vec = 8'd9; sp = 32'h3F0; entry_req = 1'b1; ret_req = 1'b1;
    @(negedge clk);
    entry_req = 1'b0; ret_req = 1'b0;
    wait_done(got);
    chk(got && acc_n == 3 && acc_we[0], "R9 entry wins over return", acc_n, 3);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_sw_entry;
    t_trap_roundtrip;
    t_trap_edges;
    t_hw_entry;
    t_hw_refuse;
    t_busy_ignore;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule